// File: doc/BRIEF.md
# Quad Byte-Lane Multiply-Accumulate Unit

This execution unit serves a 32-bit media instruction extension. One instruction names two 32-bit sources and two 32-bit destinations in a 16-entry register model. Each source is split into four byte lanes. Lane k multiplies byte k of the first source by byte k of the second source, and keeps the low 16 bits of the product. The four 16-bit lane results are packed in pairs into the two destinations.

There are two operation groups. The plain group overwrites the destinations with the products. The accumulate group adds each product to the matching 16-bit half of the old destination contents, or subtracts it from that half. A 2-bit pattern chooses add or subtract, one bit for each destination word. Signedness is mixed: in the signed variant, only the bytes of the first source are sign-extended.

The instruction is decoded and computed in the cycle that its valid strobe is high, and the results are registered at the following clock edge. A load port and a combinational peek port let the surrounding logic fill the register model and inspect it.

Top module: `qmac_unit`

## Requirements
- R1: While reset is asserted, and once it is released, all 16 registers read zero, and done_o and reserved_o are low.
- R2: A load (load_en high) writes load_data into entry load_idx at the clock edge. peek_data always shows entry peek_idx combinationally.
- R3: Major opcode bits[5:0]=0x38 with bits[25:22]=0000 is an unsigned multiply. Both bytes of each lane are zero-extended, and each lane keeps the low 16 bits of its product.
- R4: Major opcode 0x38 with bits[25:22]=0010 is the mixed-sign multiply. Each first-source byte is sign-extended and each second-source byte is zero-extended.
- R5: Field positions are: first source in bits[13:10], second source in bits[17:14], low destination in bits[21:18], high destination in bits[9:6]. Lane 0 goes to low[15:0], lane 1 to low[31:16], lane 2 to high[15:0] and lane 3 to high[31:16].
- R6: Major opcode 0x3A is multiply-accumulate. Bits[23:22]=00 selects unsigned and 10 selects mixed-sign. Each lane combines with the old 16-bit half at its own output position, wrapping modulo 2^16 with no carry between lanes.
- R7: In the accumulate group, bit 24 set gives old minus product for lanes 0 and 1, and bit 25 set does the same for lanes 2 and 3. A clear bit gives old plus product.
- R8: A strobe is reserved in two cases: major 0x38 with bits[25:22] other than 0000 or 0010, and major 0x3A with bits[23:22] equal to 01 or 11. A reserved strobe pulses reserved_o for one cycle after the edge and changes no register.
- R9: A strobe with any other major opcode changes no register and raises neither flag.
- R10: All operands, including the old destination values, are read before any write. When both destination fields name the same entry, the high-destination word is the one stored.
- R11: Results appear on peek_data after the clock edge that samples the strobe, and not before it. done_o is high for exactly that one following cycle.
- R12: When a load and an executing instruction write the same entry at the same edge, the instruction result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | Instruction strobe |
| issue_instr | input | 32 | Instruction word |
| load_en | input | 1 | Register load enable |
| load_idx | input | 4 | Register load index |
| load_data | input | 32 | Register load data |
| peek_idx | input | 4 | Register read index |
| peek_data | output | 32 | Register contents at peek_idx |
| done_o | output | 1 | An instruction wrote back at the last edge |
| reserved_o | output | 1 | A reserved encoding was seen at the last edge |

## Verification
The bench targets byte lanes whose top bit is set in either source. A design that sign-extends the second source, or forgets to extend the first, gives results such as 0xFFFF or 0x01FE where 0xFFFE and 0x00FF are expected. Accumulation at 0xFFFF and subtraction below zero catch carries that leak into the next lane and add/subtract bits that are swapped between the two words. Stimulus also covers aliased destinations, a source that doubles as the accumulator, and a load that collides with a writeback. A design that writes in the wrong order, or reads after writing, stores the wrong word in these cases. Reserved encodings, including nonzero pattern bits in the plain group, must leave every register as it was.

// File: rtl/qmac_pkg.sv
`timescale 1ns/1ps
package qmac_pkg;
  localparam int INSTR_W  = 32;
  localparam int FLD_W    = 4;
  localparam int MAJ_LSB  = 0;
  localparam int MAJ_W    = 6;
  localparam int DHI_LSB  = 6;
  localparam int SRCA_LSB = 10;
  localparam int SRCB_LSB = 14;
  localparam int DLO_LSB  = 18;
  localparam int SUB_LSB  = 22;
  localparam int SUB_W    = 4;
  localparam int PAT_W    = 2;

  localparam logic [MAJ_W-1:0] MAJOR_MUL = 6'h38;
  localparam logic [MAJ_W-1:0] MAJOR_MAC = 6'h3A;
  localparam logic [1:0]       SEL_UNS   = 2'b00;
  localparam logic [1:0]       SEL_MIX   = 2'b10;

  typedef logic [FLD_W-1:0] ridx_t;

  typedef struct packed {
    logic             go;
    logic             rsvd;
    logic             sgn;
    logic             mac;
    logic [PAT_W-1:0] sub_pat;
    ridx_t            src_a;
    ridx_t            src_b;
    ridx_t            dst_lo;
    ridx_t            dst_hi;
  } qmac_dec_t;
endpackage

// File: rtl/qmac_rst_sync.sv
`timescale 1ns/1ps
module qmac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/qmac_decode.sv
`timescale 1ns/1ps
module qmac_decode
  import qmac_pkg::*;
(
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output qmac_dec_t          dec_o
);
  logic [MAJ_W-1:0] major;
  logic [SUB_W-1:0] sub;
  logic [1:0]       sel;
  logic             is_mul;
  logic             is_mac;
  logic             legal_mul;
  logic             legal_mac;
  logic             hit;
  logic             legal;
  logic             unused_top;

  assign unused_top = ^instr_i[INSTR_W-1:SUB_LSB+SUB_W];

  always_comb begin
    major     = instr_i[MAJ_LSB +: MAJ_W];
    sub       = instr_i[SUB_LSB +: SUB_W];
    sel       = sub[1:0];
    is_mul    = (major == MAJOR_MUL);
    is_mac    = (major == MAJOR_MAC);
    // plain group decodes the whole sub-field, pattern bits must be zero
    legal_mul = (sub == {2'b00, SEL_UNS}) || (sub == {2'b00, SEL_MIX});
    legal_mac = (sel == SEL_UNS) || (sel == SEL_MIX);
    hit       = valid_i && (is_mul || is_mac);
    legal     = is_mul ? legal_mul : legal_mac;

    dec_o.go      = hit && legal;
    dec_o.rsvd    = hit && !legal;
    dec_o.sgn     = sel[1];
    dec_o.mac     = is_mac;
    dec_o.sub_pat = is_mac ? sub[SUB_W-1:2] : '0;
    dec_o.src_a   = instr_i[SRCA_LSB +: FLD_W];
    dec_o.src_b   = instr_i[SRCB_LSB +: FLD_W];
    dec_o.dst_lo  = instr_i[DLO_LSB  +: FLD_W];
    dec_o.dst_hi  = instr_i[DHI_LSB  +: FLD_W];
  end
endmodule

// File: rtl/qmac_lane.sv
`timescale 1ns/1ps
module qmac_lane #(
  parameter  int LANE_W = 8,
  localparam int PROD_W = 2 * LANE_W
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic [PROD_W-1:0] acc_i,
  input  logic              sgn_i,
  input  logic              mac_i,
  input  logic              sub_i,
  output logic [PROD_W-1:0] res_o
);
  logic [PROD_W-1:0] a_ext;
  logic [PROD_W-1:0] b_ext;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] comb;

  always_comb begin
    // first operand may be sign-extended, second is always zero-extended
    a_ext = {{LANE_W{sgn_i & a_i[LANE_W-1]}}, a_i};
    b_ext = {{LANE_W{1'b0}}, b_i};
    prod  = a_ext * b_ext;
    comb  = sub_i ? (acc_i - prod) : (acc_i + prod);
    res_o = mac_i ? comb : prod;
  end
endmodule

// File: rtl/qmac_regfile.sv
`timescale 1ns/1ps
module qmac_regfile #(
  parameter  int WORD_W  = 32,
  parameter  int IDX_W   = 4,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_en,
  input  logic [IDX_W-1:0]                ld_idx,
  input  logic [WORD_W-1:0]               ld_data,
  input  logic                            wlo_en,
  input  logic [IDX_W-1:0]                wlo_idx,
  input  logic [WORD_W-1:0]               wlo_data,
  input  logic                            whi_en,
  input  logic [IDX_W-1:0]                whi_idx,
  input  logic [WORD_W-1:0]               whi_data,
  output logic [ENTRIES-1:0][WORD_W-1:0]  mem_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              en;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] q;

    // later assignments win: load < low destination < high destination
    always_comb begin
      en  = 1'b0;
      nxt = q;
      if (ld_en && (ld_idx == IDX_W'(e))) begin
        en  = 1'b1;
        nxt = ld_data;
      end
      if (wlo_en && (wlo_idx == IDX_W'(e))) begin
        en  = 1'b1;
        nxt = wlo_data;
      end
      if (whi_en && (whi_idx == IDX_W'(e))) begin
        en  = 1'b1;
        nxt = whi_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
    end

    assign mem_o[e] = q;
  end
endmodule

// File: rtl/qmac_unit.sv
`timescale 1ns/1ps
module qmac_unit
  import qmac_pkg::*;
#(
  parameter  int LANE_W   = 8,
  parameter  int LANES    = 4,
  localparam int WORD_W   = LANE_W * LANES,
  localparam int PROD_W   = 2 * LANE_W,
  localparam int PER_WORD = WORD_W / PROD_W,
  localparam int DST_N    = LANES / PER_WORD,
  localparam int REG_CNT  = 1 << FLD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  input  logic [INSTR_W-1:0] issue_instr,
  input  logic               load_en,
  input  logic [FLD_W-1:0]   load_idx,
  input  logic [WORD_W-1:0]  load_data,
  input  logic [FLD_W-1:0]   peek_idx,
  output logic [WORD_W-1:0]  peek_data,
  output logic               done_o,
  output logic               reserved_o
);
  logic                              rst_core_n;
  qmac_dec_t                         dec;
  logic [REG_CNT-1:0][WORD_W-1:0]    regs;
  logic [WORD_W-1:0]                 src_a_w;
  logic [WORD_W-1:0]                 src_b_w;
  logic [DST_N-1:0][WORD_W-1:0]      dst_old;
  logic [DST_N-1:0][WORD_W-1:0]      dst_new;
  logic                              done_d;
  logic                              rsvd_d;
  logic                              done_q;
  logic                              rsvd_q;

  qmac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  qmac_decode u_dec (
    .valid_i (issue_valid),
    .instr_i (issue_instr),
    .dec_o   (dec)
  );

  // every operand is read from the pre-edge register state
  always_comb begin
    src_a_w    = regs[dec.src_a];
    src_b_w    = regs[dec.src_b];
    dst_old[0] = regs[dec.dst_lo];
    dst_old[1] = regs[dec.dst_hi];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int DW = k / PER_WORD;
    localparam int SL = k % PER_WORD;
    qmac_lane #(.LANE_W(LANE_W)) u_lane (
      .a_i   (src_a_w[k*LANE_W +: LANE_W]),
      .b_i   (src_b_w[k*LANE_W +: LANE_W]),
      .acc_i (dst_old[DW][SL*PROD_W +: PROD_W]),
      .sgn_i (dec.sgn),
      .mac_i (dec.mac),
      .sub_i (dec.sub_pat[DW]),
      .res_o (dst_new[DW][SL*PROD_W +: PROD_W])
    );
  end

  qmac_regfile #(.WORD_W(WORD_W), .IDX_W(FLD_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ld_en    (load_en),
    .ld_idx   (load_idx),
    .ld_data  (load_data),
    .wlo_en   (dec.go),
    .wlo_idx  (dec.dst_lo),
    .wlo_data (dst_new[0]),
    .whi_en   (dec.go),
    .whi_idx  (dec.dst_hi),
    .whi_data (dst_new[1]),
    .mem_o    (regs)
  );

  always_comb begin
    done_d = dec.go;
    rsvd_d = dec.rsvd;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= 1'b0;
      rsvd_q <= 1'b0;
    end else begin
      done_q <= done_d;
      rsvd_q <= rsvd_d;
    end
  end

  assign done_o     = done_q;
  assign reserved_o = rsvd_q;
  assign peek_data  = regs[peek_idx];
endmodule

// File: rtl/qmac_unit_chk.sv
`timescale 1ns/1ps
module qmac_unit_chk #(
  parameter int WORD_W  = 32,
  parameter int REG_CNT = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           issue_valid,
  input logic [31:0]                    issue_instr,
  input logic                           load_en,
  input logic [REG_CNT-1:0][WORD_W-1:0] regs,
  input logic                           done_o,
  input logic                           reserved_o
);
  logic [15:0] exp_l0;
  logic [WORD_W-1:0] wa;
  logic [WORD_W-1:0] wb;

  assign wa     = regs[issue_instr[13:10]];
  assign wb     = regs[issue_instr[17:14]];
  assign exp_l0 = {8'h00, wa[7:0]} * {8'h00, wb[7:0]};

  // R3
  mul_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_instr[5:0] == 6'h38 && issue_instr[25:22] == 4'h0
     && issue_instr[21:18] != issue_instr[9:6])
    |=> (regs[$past(issue_instr[21:18])][15:0] == $past(exp_l0)));

  // R8
  rsvd_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !load_en && issue_instr[5:0] == 6'h38
     && issue_instr[25:22] != 4'h0 && issue_instr[25:22] != 4'h2)
    |=> (reserved_o && !done_o && $stable(regs)));

  // R8
  rsvd_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !load_en && issue_instr[5:0] == 6'h3A && issue_instr[22])
    |=> (reserved_o && !done_o && $stable(regs)));

  // R9
  foreign_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !load_en && issue_instr[5:0] != 6'h38 && issue_instr[5:0] != 6'h3A)
    |=> (!reserved_o && !done_o && $stable(regs)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_valid && !load_en) |=> (!done_o && !reserved_o && $stable(regs)));

  // R11
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(issue_valid));
endmodule

bind qmac_unit qmac_unit_chk #(.WORD_W(32), .REG_CNT(16)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .issue_valid (issue_valid),
  .issue_instr (issue_instr),
  .load_en     (load_en),
  .regs        (regs),
  .done_o      (done_o),
  .reserved_o  (reserved_o)
);

// File: tb/sim_qmac_unit.sv
`timescale 1ns/1ps
module sim_qmac_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [31:0] issue_instr;
  logic        load_en;
  logic [3:0]  load_idx;
  logic [31:0] load_data;
  logic [3:0]  peek_idx;
  logic [31:0] peek_data;
  logic        done_o;
  logic        reserved_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          ended = 0;

  always #4 clk = ~clk;

  qmac_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
    .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
    .peek_idx(peek_idx), .peek_data(peek_data), .done_o(done_o), .reserved_o(reserved_o)
  );

  // fields: op[131:130] (bit1 accumulate, bit0 mixed-sign), pat[129:128], a, b, old low, old high
  localparam logic [131:0] VECS [8] = '{
    {2'd0, 2'd0, 32'h0102_0304, 32'h0506_0708, 32'h0, 32'h0},
    {2'd0, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1111_1111, 32'h2222_2222},
    {2'd1, 2'd0, 32'h80FF_7F01, 32'hFF80_0281, 32'h0, 32'h0},
    {2'd1, 2'd0, 32'hC0A0_9080, 32'h0403_0201, 32'h0, 32'h0},
    {2'd2, 2'd0, 32'h1020_3040, 32'h0203_0405, 32'h1234_5678, 32'h9ABC_DEF0},
    {2'd2, 2'd3, 32'hFFFF_FFFF, 32'h0101_0101, 32'h0000_0000, 32'h0001_0001},
    {2'd3, 2'd1, 32'hFE80_7FFF, 32'h10FF_FF02, 32'h8000_7FFF, 32'hFFFF_0000},
    {2'd3, 2'd2, 32'h8181_8181, 32'hFFFF_FFFF, 32'h0100_0100, 32'hFFFF_FFFF}
  };

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] lane_ref(input logic [7:0] a, input logic [7:0] b,
      input logic sg, input logic mac, input logic sub, input logic [15:0] old);
    int av;
    int p;
    logic [15:0] p16;
    av  = sg ? int'($signed(a)) : int'(a);
    p   = av * int'(b);
    p16 = p[15:0];
    if (!mac) return p16;
    return sub ? 16'(old - p16) : 16'(old + p16);
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] maj, input logic [3:0] sub,
      input logic [3:0] sa, input logic [3:0] sb, input logic [3:0] dl, input logic [3:0] dh);
    return {6'b0, sub, dl, sb, sa, dh, maj};
  endfunction

  function automatic logic [31:0] mk_op(input logic [1:0] op, input logic [1:0] pat,
      input logic [3:0] sa, input logic [3:0] sb, input logic [3:0] dl, input logic [3:0] dh);
    return mk(op[1] ? 6'h3A : 6'h38, {op[1] ? pat : 2'b00, op[0], 1'b0}, sa, sb, dl, dh);
  endfunction

  task automatic load_reg(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    load_en = 1'b1; load_idx = idx; load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] idx, output logic [31:0] d);
    peek_idx = idx;
    #0.1;
    d = peek_data;
  endtask

  task automatic issue(input logic [31:0] ins, output logic d, output logic r);
    @(negedge clk);
    issue_instr = ins; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    d = done_o; r = reserved_o;
  endtask

  task automatic run_vec(input logic [1:0] op, input logic [1:0] pat, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] ol, input logic [31:0] oh, input string tag);
    logic [31:0] el, eh, gl, gh;
    logic d, r;
    el = {lane_ref(a[15:8],  b[15:8],  op[0], op[1], pat[0], ol[31:16]),
          lane_ref(a[7:0],   b[7:0],   op[0], op[1], pat[0], ol[15:0])};
    eh = {lane_ref(a[31:24], b[31:24], op[0], op[1], pat[1], oh[31:16]),
          lane_ref(a[23:16], b[23:16], op[0], op[1], pat[1], oh[15:0])};
    load_reg(4'd1, a); load_reg(4'd2, b); load_reg(4'd3, ol); load_reg(4'd4, oh);
    issue(mk_op(op, pat, 4'd1, 4'd2, 4'd3, 4'd4), d, r);
    peek(4'd3, gl); peek(4'd4, gh);
    chk({tag, " done"}, {31'b0, d}, 32'd1);
    chk({tag, " low word"}, gl, el);
    chk({tag, " high word"}, gh, eh);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] g;
    logic d, r;
    rst_n = 1'b0; issue_valid = 1'b0; issue_instr = '0;
    load_en = 1'b0; load_idx = '0; load_data = '0; peek_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 done", {31'b0, done_o}, 32'd0);
    chk("R1 reserved", {31'b0, reserved_o}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      peek(4'(i), g);
      chk("R1 reg zero", g, 32'd0);
    end

    // R2 load and peek
    load_reg(4'd7, 32'hDEAD_BEEF);
    peek(4'd7, g); chk("R2 load", g, 32'hDEAD_BEEF);

    // vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      run_vec(VECS[v][131:130], VECS[v][129:128], VECS[v][127:96], VECS[v][95:64],
              VECS[v][63:32], VECS[v][31:0], "R3/R4/R5/R6/R7 table");
    end

    // R4 mixed sign, literal: lane0 -1*2, lane1 1*255
    run_vec(2'd1, 2'd0, 32'h0000_01FF, 32'h0000_FF02, 32'h0, 32'h0, "R4 model");
    peek(4'd3, g); chk("R4 literal", g, 32'h00FF_FFFE);
    run_vec(2'd0, 2'd0, 32'h0000_01FF, 32'h0000_FF02, 32'h0, 32'h0, "R3 model");
    peek(4'd3, g); chk("R3 literal", g, 32'h00FF_01FE);

    // R6 wrap without carry into lane 1
    run_vec(2'd2, 2'd0, 32'h0000_0001, 32'h0000_0001, 32'h0000_FFFF, 32'h5555_AAAA, "R6 model");
    peek(4'd3, g); chk("R6 wrap", g, 32'h0000_0000);
    peek(4'd4, g); chk("R6 high untouched", g, 32'h5555_AAAA);

    // R7 subtract low pair only
    run_vec(2'd2, 2'd1, 32'h0101_0001, 32'h0101_0001, 32'h0000_0000, 32'h0000_0000, "R7 model");
    peek(4'd3, g); chk("R7 low subtract", g, 32'h0000_FFFF);
    peek(4'd4, g); chk("R7 high add", g, 32'h0001_0001);

    // random sweep over every operation and pattern
    for (int i = 0; i < 32; i++) begin
      run_vec(2'(i % 4), 2'(i / 4), $urandom, $urandom, $urandom, $urandom, "R3/R6/R7 random");
    end

    // R8 reserved encodings leave registers unchanged
    load_reg(4'd3, 32'hA5A5_0F0F); load_reg(4'd4, 32'h1234_4321);
    issue(mk(6'h38, 4'b0001, 4'd1, 4'd2, 4'd3, 4'd4), d, r);
    chk("R8 plain sel 01 flag", {30'b0, r, d}, 32'd2);
    issue(mk(6'h38, 4'b0110, 4'd1, 4'd2, 4'd3, 4'd4), d, r);
    chk("R8 plain pattern bits flag", {30'b0, r, d}, 32'd2);
    issue(mk(6'h3A, 4'b0011, 4'd1, 4'd2, 4'd3, 4'd4), d, r);
    chk("R8 acc sel 11 flag", {30'b0, r, d}, 32'd2);
    peek(4'd3, g); chk("R8 low unchanged", g, 32'hA5A5_0F0F);
    peek(4'd4, g); chk("R8 high unchanged", g, 32'h1234_4321);

    // R9 foreign major opcode
    issue(mk(6'h39, 4'b0000, 4'd1, 4'd2, 4'd3, 4'd4), d, r);
    chk("R9 no flags", {30'b0, r, d}, 32'd0);
    peek(4'd3, g); chk("R9 low unchanged", g, 32'hA5A5_0F0F);
    peek(4'd4, g); chk("R9 high unchanged", g, 32'h1234_4321);

    // R10 both destinations alias: high word wins
    load_reg(4'd1, 32'h0403_0201); load_reg(4'd2, 32'h0101_0101);
    issue(mk_op(2'd0, 2'd0, 4'd1, 4'd2, 4'd5, 4'd5), d, r);
    peek(4'd5, g); chk("R10 alias high wins", g, 32'h0004_0003);

    // R10 source equals accumulator, uses old value
    load_reg(4'd3, 32'h0000_0002); load_reg(4'd2, 32'h0000_0003); load_reg(4'd4, 32'h0);
    issue(mk_op(2'd2, 2'd0, 4'd3, 4'd2, 4'd3, 4'd4), d, r);
    peek(4'd3, g); chk("R10 read before write", g, 32'h0000_0008);

    // R11 not visible before the edge, done lasts one cycle
    load_reg(4'd1, 32'h0000_0003); load_reg(4'd2, 32'h0000_0005); load_reg(4'd3, 32'h0);
    @(negedge clk);
    issue_instr = mk_op(2'd0, 2'd0, 4'd1, 4'd2, 4'd3, 4'd4); issue_valid = 1'b1;
    peek(4'd3, g); chk("R11 before edge", g, 32'h0);
    @(negedge clk);
    issue_valid = 1'b0;
    peek(4'd3, g); chk("R11 after edge", g, 32'h0000_000F);
    chk("R11 done high", {31'b0, done_o}, 32'd1);
    @(negedge clk);
    chk("R11 done one cycle", {31'b0, done_o}, 32'd0);

    // R12 load and writeback to the same entry
    @(negedge clk);
    issue_instr = mk_op(2'd0, 2'd0, 4'd1, 4'd2, 4'd3, 4'd4); issue_valid = 1'b1;
    load_en = 1'b1; load_idx = 4'd3; load_data = 32'hFFFF_FFFF;
    @(negedge clk);
    issue_valid = 1'b0; load_en = 1'b0;
    peek(4'd3, g); chk("R12 writeback wins", g, 32'h0000_000F);

    // R1 reset in mid-run clears state
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    peek(4'd3, g); chk("R1 mid-run reset", g, 32'h0);
    peek(4'd7, g); chk("R1 mid-run reset", g, 32'h0);
    chk("R1 mid-run done", {31'b0, done_o}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule